// File: doc/BRIEF.md
# Routed external interrupt controller

This block collects 256 level-sensitive interrupt inputs and steers each one to a single core and a single interrupt pin on that core. Four cores are served, and each core has four pin outputs. Software configures the block through a memory-mapped register space. That space holds an enable bit per source, a one-hot pin-selection byte for each group of 32 sources, and a one-hot core-selection byte for each source. It also holds two plain storage arrays that have no effect on routing: one for node type and one for bounce.

When an enabled source rises, it latches a status bit in its target core's status array. The core's pin stays high while any latched source is routed to it. Software clears latched bits by writing ones into its own core's view of the status array. Changing an enable bit or a core-selection byte re-evaluates sources that are already pending. A disabled pending source is withdrawn. A newly enabled pending source is raised. A pending source whose target core changes is moved from the old core to the new one.

A request carries an offset, a size code, write data and the requester's core number. The block answers every request exactly one cycle later with a valid strobe, an error flag and read data.

Top module: `xirq_ctrl`

## Requirements
- R1: After synchronous reset, every stored register, raw pending bit and latched status bit is zero. All pin outputs, `rsp_valid` and `rsp_err` are low.
- R2: Each request cycle produces `rsp_valid` high in the next cycle only. The size code is 0 for 1 byte, 1 for 4 bytes, 2 for 8 bytes; code 3 is an error. The offset is aligned down to the access size. Byte lane i of the data bus (bits 8i+7..8i) maps to aligned offset + i. `rsp_err` is set for size code 3 or for an aligned offset outside all regions. An errored request changes nothing. `rsp_rdata` is zero except on a successful read.
- R3: Bytes written to node type (0x0A0–0x0BF), pin map (0x0C0–0x0C7), enable (0x200–0x21F), bounce (0x280–0x29F) and core map (0x800–0x8FF) read back unchanged at any access size. Source s occupies enable byte s/8, bit s%8, and core-map byte s.
- R4: Sources 32g..32g+31 use pin-map byte g. The pin is the index of that byte's lowest set bit. An index of 4 or more, or an all-zero byte, selects pin 0.
- R5: The target core of source s is the index of the lowest set bit of core-map byte s. An index of 4 or more, or an all-zero byte, selects core 0.
- R6: A rising input sets its raw pending bit (read at 0x300 + s/8, bit s%8) from the next cycle. If the source is enabled, the same edge also latches the source's bit in its target core's status array. If the source is disabled, only the raw bit changes.
- R7: A falling input clears only its raw pending bit. A latched status bit is kept.
- R8: Pin output index 4c+p is high exactly when core c has at least one latched source whose pin is p. It is registered and changes in the cycle after its cause.
- R9: Offsets 0x400–0x41F are the requester's own status array, with source s at byte s/8, bit s%8. Reads return that array. Writing a 1 clears the bit and writing a 0 keeps it. Offsets 0x420–0x71F are accepted, read as zero and ignore writes.
- R10: An enable bit written 0→1 while the source is pending latches the source at its target core. An enable bit written 1→0 while the source is pending clears that latched bit.
- R11: A core-map write that changes the target of a pending source clears the bit at the old core. It then latches the bit at the new core if the source is enabled. If the target is unchanged, or the source is not pending, only the byte is stored.
- R12: Writes to the raw pending range are accepted and ignored. Node-type, bounce and pin-map writes store only and alter no latched or raw bit.
- R13: When a write and an input rise act on the same source in one cycle, the write's clear effects apply first and the rise's latch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 256 | Synchronous level interrupt inputs |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0=1B, 1=4B, 2=8B, 3=invalid |
| req_addr | input | 12 | Byte offset from block base |
| req_wdata | input | 64 | Write data, lane i = aligned offset + i |
| req_core | input | 2 | Core number of the requester |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| pin_out | output | 16 | Interrupt pins, index 4*core + pin |

## Verification
The bench builds the block with its default sizes: 256 sources in 8 pin groups, 4 cores and 4 pins per core. These sizes make the corner cases reachable. Out-of-range one-hot indices 4 to 7 and empty map bytes can reach both the core and pin fallbacks. Every status byte of every core can be addressed. The four cores also allow a single source to be moved across several cores. A behavioural model runs beside the design and compares the response and all 16 pins on every clock. The run ends with random traffic that mixes reads, writes, invalid sizes and input toggles.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_BAD = 2'd3} acc_size_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_NODE, RG_PMAP, RG_EN, RG_BNC, RG_ISR, RG_STAT, RG_CMAP
  } region_e;

  localparam logic [11:0] NODE_LO = 12'h0A0, NODE_HI = 12'h0BF;
  localparam logic [11:0] PMAP_LO = 12'h0C0, PMAP_HI = 12'h0C7;
  localparam logic [11:0] EN_LO   = 12'h200, EN_HI   = 12'h21F;
  localparam logic [11:0] BNC_LO  = 12'h280, BNC_HI  = 12'h29F;
  localparam logic [11:0] ISR_LO  = 12'h300, ISR_HI  = 12'h31F;
  localparam logic [11:0] STAT_LO = 12'h400, STAT_HI = 12'h71F;
  localparam logic [11:0] CMAP_LO = 12'h800, CMAP_HI = 12'h8FF;

  // Index of the lowest set bit of a one-hot selector byte; empty or
  // out-of-range values fall back to zero.
  function automatic int unsigned low_sel(input logic [7:0] b, input int unsigned lim);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      if (b[i]) r = unsigned'(i);
    end
    if (r >= lim) r = 0;
    return r;
  endfunction
endpackage

// File: rtl/xirq_decode.sv
module xirq_decode
  import xirq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  output logic          acc_ok,
  output logic          acc_err,
  output logic [AW-1:0] base,
  output logic [AW-1:0] lmask,
  output region_e       region
);
  always_comb begin
    unique case (acc_size_e'(req_size))
      SZ_BYTE:  lmask = AW'(0);
      SZ_WORD:  lmask = AW'(3);
      SZ_DWORD: lmask = AW'(7);
      default:  lmask = AW'(0);
    endcase
    base = req_addr & ~lmask;
    if      (base >= NODE_LO && base <= NODE_HI) region = RG_NODE;
    else if (base >= PMAP_LO && base <= PMAP_HI) region = RG_PMAP;
    else if (base >= EN_LO   && base <= EN_HI)   region = RG_EN;
    else if (base >= BNC_LO  && base <= BNC_HI)  region = RG_BNC;
    else if (base >= ISR_LO  && base <= ISR_HI)  region = RG_ISR;
    else if (base >= STAT_LO && base <= STAT_HI) region = RG_STAT;
    else if (base >= CMAP_LO && base <= CMAP_HI) region = RG_CMAP;
    else                                         region = RG_NONE;
    acc_err = req_valid && ((req_size == 2'd3) || (region == RG_NONE));
    acc_ok  = req_valid && !acc_err;
  end
endmodule

// File: rtl/xirq_bytereg.sv
module xirq_bytereg #(
  parameter int          AW     = 12,
  parameter int          DW     = 64,
  parameter int          NBYTES = 32,
  parameter logic [11:0] LO     = 12'h000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ok,
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       lmask,
  input  logic [DW-1:0]       wdata,
  output logic [NBYTES*8-1:0] nxt,
  output logic [NBYTES*8-1:0] q
);
  localparam int LW = $clog2(DW / 8);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [AW-1:0] OFF = AW'(LO) + AW'(i);
    logic          hit;
    logic [LW-1:0] lane;
    assign hit  = wr_ok && ((OFF & ~lmask) == base);
    assign lane = OFF[LW-1:0] & lmask[LW-1:0];
    assign nxt[i*8 +: 8] = hit ? wdata[{lane, 3'b000} +: 8] : q[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/xirq_route.sv
module xirq_route
  import xirq_pkg::*;
#(
  parameter int NSRC  = 256,
  parameter int NCORE = 4,
  parameter int NPIN  = 4,
  parameter int CW    = $clog2(NCORE),
  parameter int PW    = $clog2(NPIN)
) (
  input  logic [NSRC*8-1:0]      cmap_old,
  input  logic [NSRC*8-1:0]      cmap_new,
  input  logic [NSRC/32*8-1:0]   pmap,
  output logic [NSRC*CW-1:0]     core_old,
  output logic [NSRC*CW-1:0]     core_new,
  output logic [NSRC*PW-1:0]     pin_sel
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign core_old[s*CW +: CW] = CW'(low_sel(cmap_old[s*8 +: 8], NCORE));
    assign core_new[s*CW +: CW] = CW'(low_sel(cmap_new[s*8 +: 8], NCORE));
    assign pin_sel[s*PW +: PW]  = PW'(low_sel(pmap[(s/32)*8 +: 8], NPIN));
  end
endmodule

// File: rtl/xirq_status.sv
module xirq_status #(
  parameter int NSRC  = 256,
  parameter int NCORE = 4,
  parameter int NPIN  = 4,
  parameter int CW    = $clog2(NCORE),
  parameter int PW    = $clog2(NPIN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       isr_q,
  input  logic [NSRC-1:0]       rise,
  input  logic [NSRC-1:0]       en_q,
  input  logic [NSRC-1:0]       en_d,
  input  logic [NSRC*CW-1:0]    core_old,
  input  logic [NSRC*CW-1:0]    core_new,
  input  logic [NSRC*PW-1:0]    pin_sel,
  input  logic                  w1c_en,
  input  logic [CW-1:0]         w1c_core,
  input  logic [NSRC-1:0]       w1c_mask,
  output logic [NCORE*NSRC-1:0] stat_q,
  output logic [NCORE*NPIN-1:0] pin_out
);
  logic [NCORE*NSRC-1:0] stat_d;
  logic [NCORE*NPIN-1:0] pin_d;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [CW-1:0] co, cn;
      logic          moved, clr, set;
      assign co    = core_old[s*CW +: CW];
      assign cn    = core_new[s*CW +: CW];
      assign moved = (co != cn);
      // write effects first: withdraw on w1c, disable of pending, move away
      assign clr = (w1c_en && (w1c_core == CW'(c)) && w1c_mask[s])
                || (isr_q[s] && en_q[s] && !en_d[s] && (co == CW'(c)))
                || (isr_q[s] && moved && (co == CW'(c)));
      // raise at the (new) target: enable of pending, arrival by move, input edge
      assign set = (cn == CW'(c)) && en_d[s]
                && ((isr_q[s] && (!en_q[s] || moved)) || rise[s]);
      assign stat_d[c*NSRC + s] = (stat_q[c*NSRC + s] && !clr) || set;

      // R6/R11: a latch appears only for an enabled source at its chosen core
      p_latch_target_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[c*NSRC + s]) |-> en_q[s] && ($past(core_new[s*CW +: CW]) == CW'(c)));
      // R7: without a write touching the source, a latched bit is kept
      p_hold_without_write_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_q[c*NSRC + s] && !w1c_en && (en_q[s] == en_d[s])
         && (core_old[s*CW +: CW] == core_new[s*CW +: CW])) |=> stat_q[c*NSRC + s]);
    end
  end

  always_comb begin
    pin_d = '0;
    for (int c = 0; c < NCORE; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (stat_d[c*NSRC + s]) pin_d[c*NPIN + int'(pin_sel[s*PW +: PW])] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      pin_out <= '0;
    end else begin
      stat_q  <= stat_d;
      pin_out <= pin_d;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_pin_chk
    for (genvar p = 0; p < NPIN; p++) begin : g_p
      p_pin_has_source_r8: assert property (@(posedge clk) disable iff (rst)
        pin_out[c*NPIN + p] |-> (|stat_q[c*NSRC +: NSRC]));
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NSRC  = 256,
  parameter int NCORE = 4,
  parameter int NPIN  = 4,
  parameter int AW    = 12,
  parameter int DW    = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       irq_in,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic [$clog2(NCORE)-1:0] req_core,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DW-1:0]         rsp_rdata,
  output logic [NCORE*NPIN-1:0] pin_out
);
  localparam int CW    = $clog2(NCORE);
  localparam int PW    = $clog2(NPIN);
  localparam int NGRP  = NSRC / 32;
  localparam int NBYTE = NSRC / 8;
  localparam int NB    = DW / 8;
  localparam int LW    = $clog2(NB);

  logic          acc_ok, acc_err, wr_ok, w1c_en;
  logic [AW-1:0] base, lmask;
  region_e       region;

  logic [NSRC-1:0]       in_q, rise, en_q, en_d, w1c_mask;
  logic [NBYTE*8-1:0]    ntype_q, bnc_q;
  logic [NGRP*8-1:0]     pmap_q;
  logic [NSRC*8-1:0]     cmap_q, cmap_d;
  logic [NBYTE*8-1:0]    unused_ntype_d, unused_bnc_d;
  logic [NGRP*8-1:0]     unused_pmap_d;
  logic [NSRC*CW-1:0]    core_old, core_new;
  logic [NSRC*PW-1:0]    pin_sel;
  logic [NCORE*NSRC-1:0] stat_q;
  logic [DW-1:0]         rd_word;

  xirq_decode #(.AW(AW)) u_dec (
    .req_valid(req_valid), .req_size(req_size), .req_addr(req_addr),
    .acc_ok(acc_ok), .acc_err(acc_err), .base(base), .lmask(lmask), .region(region)
  );

  assign wr_ok  = acc_ok && req_write;
  assign w1c_en = wr_ok && (region == RG_STAT);

  xirq_bytereg #(.AW(AW), .DW(DW), .NBYTES(NBYTE), .LO(NODE_LO)) u_ntype (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .base(base), .lmask(lmask),
    .wdata(req_wdata), .nxt(unused_ntype_d), .q(ntype_q));
  xirq_bytereg #(.AW(AW), .DW(DW), .NBYTES(NGRP), .LO(PMAP_LO)) u_pmap (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .base(base), .lmask(lmask),
    .wdata(req_wdata), .nxt(unused_pmap_d), .q(pmap_q));
  xirq_bytereg #(.AW(AW), .DW(DW), .NBYTES(NBYTE), .LO(EN_LO)) u_en (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .base(base), .lmask(lmask),
    .wdata(req_wdata), .nxt(en_d), .q(en_q));
  xirq_bytereg #(.AW(AW), .DW(DW), .NBYTES(NBYTE), .LO(BNC_LO)) u_bnc (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .base(base), .lmask(lmask),
    .wdata(req_wdata), .nxt(unused_bnc_d), .q(bnc_q));
  xirq_bytereg #(.AW(AW), .DW(DW), .NBYTES(NSRC), .LO(CMAP_LO)) u_cmap (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .base(base), .lmask(lmask),
    .wdata(req_wdata), .nxt(cmap_d), .q(cmap_q));

  // write-one-to-clear mask from the requester's status view
  for (genvar j = 0; j < NBYTE; j++) begin : g_w1c
    localparam logic [AW-1:0] OFF = AW'(STAT_LO) + AW'(j);
    logic [LW-1:0] lane;
    assign lane = OFF[LW-1:0] & lmask[LW-1:0];
    assign w1c_mask[j*8 +: 8] = (w1c_en && ((OFF & ~lmask) == base))
                              ? req_wdata[{lane, 3'b000} +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= irq_in;
  end
  assign rise = irq_in & ~in_q;

  xirq_route #(.NSRC(NSRC), .NCORE(NCORE), .NPIN(NPIN), .CW(CW), .PW(PW)) u_route (
    .cmap_old(cmap_q), .cmap_new(cmap_d), .pmap(pmap_q),
    .core_old(core_old), .core_new(core_new), .pin_sel(pin_sel));

  xirq_status #(.NSRC(NSRC), .NCORE(NCORE), .NPIN(NPIN), .CW(CW), .PW(PW)) u_stat (
    .clk(clk), .rst(rst), .isr_q(in_q), .rise(rise), .en_q(en_q), .en_d(en_d),
    .core_old(core_old), .core_new(core_new), .pin_sel(pin_sel),
    .w1c_en(w1c_en), .w1c_core(req_core), .w1c_mask(w1c_mask),
    .stat_q(stat_q), .pin_out(pin_out));

  always_comb begin
    logic [AW-1:0] o;
    int unsigned   idx;
    rd_word = '0;
    for (int i = 0; i < NB; i++) begin
      o   = base + AW'(i);
      idx = 0;
      if (AW'(i) <= lmask) begin
        unique case (region)
          RG_NODE: begin idx = 32'(o - NODE_LO); rd_word[i*8 +: 8] = ntype_q[idx*8 +: 8]; end
          RG_PMAP: begin idx = 32'(o - PMAP_LO); rd_word[i*8 +: 8] = pmap_q[idx*8 +: 8]; end
          RG_EN:   begin idx = 32'(o - EN_LO);   rd_word[i*8 +: 8] = en_q[idx*8 +: 8]; end
          RG_BNC:  begin idx = 32'(o - BNC_LO);  rd_word[i*8 +: 8] = bnc_q[idx*8 +: 8]; end
          RG_ISR:  begin idx = 32'(o - ISR_LO);  rd_word[i*8 +: 8] = in_q[idx*8 +: 8]; end
          RG_STAT: begin
            idx = 32'(o - STAT_LO);
            if (idx < NBYTE) rd_word[i*8 +: 8] = stat_q[32'(req_core)*NSRC + idx*8 +: 8];
          end
          RG_CMAP: begin idx = 32'(o - CMAP_LO); rd_word[i*8 +: 8] = cmap_q[idx*8 +: 8]; end
          default: rd_word[i*8 +: 8] = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= (acc_ok && !req_write) ? rd_word : '0;
    end
  end

  p_one_cycle_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_err);
  p_bad_size_err_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd3) |=> rsp_err && (rsp_rdata == '0));
  p_raw_tracks_input_r6: assert property (@(posedge clk) disable iff (rst)
    rise != '0 |=> (in_q & $past(rise)) == $past(rise));
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 256;
  localparam int NC = 4;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [11:0]   req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic [1:0]    req_core = '0;
  logic          rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;
  logic [15:0]   pin_out;

  xirq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .pin_out(pin_out));

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  bit [7:0] m_nt[32];
  bit [7:0] m_pm[8];
  bit [7:0] m_bn[32];
  bit [7:0] m_cm[NS];
  bit       m_en[NS];
  bit       m_in[NS];
  bit       m_st[NC][NS];
  bit        exp_rv, exp_err;
  bit [63:0] exp_rd;
  bit [15:0] exp_pin;

  function automatic int pick(bit [7:0] b, int lim);
    int r = -1;
    for (int i = 0; i < 8; i++) if (b[i] && r < 0) r = i;
    if (r < 0 || r >= lim) r = 0;
    return r;
  endfunction

  function automatic bit in_range(int o, int lo, int hi);
    return o >= lo && o <= hi;
  endfunction

  function automatic bit mapped(int o);
    return in_range(o, 'hA0, 'hBF) || in_range(o, 'hC0, 'hC7) || in_range(o, 'h200, 'h21F)
        || in_range(o, 'h280, 'h29F) || in_range(o, 'h300, 'h31F) || in_range(o, 'h400, 'h71F)
        || in_range(o, 'h800, 'h8FF);
  endfunction

  function automatic bit [7:0] rbyte(int o, int core);
    bit [7:0] v = 0;
    if (in_range(o, 'hA0, 'hBF)) v = m_nt[o - 'hA0];
    else if (in_range(o, 'hC0, 'hC7)) v = m_pm[o - 'hC0];
    else if (in_range(o, 'h200, 'h21F)) for (int k = 0; k < 8; k++) v[k] = m_en[(o - 'h200) * 8 + k];
    else if (in_range(o, 'h280, 'h29F)) v = m_bn[o - 'h280];
    else if (in_range(o, 'h300, 'h31F)) for (int k = 0; k < 8; k++) v[k] = m_in[(o - 'h300) * 8 + k];
    else if (in_range(o, 'h400, 'h41F)) for (int k = 0; k < 8; k++) v[k] = m_st[core][(o - 'h400) * 8 + k];
    else if (in_range(o, 'h800, 'h8FF)) v = m_cm[o - 'h800];
    return v;
  endfunction

  task automatic model_step();
    int msk, base, core;
    bit err;
    bit [7:0] n_pm[8];
    bit [7:0] n_cm[NS];
    bit       n_en[NS];
    bit       n_st[NC][NS];
    bit [NS-1:0] w1c;
    if (rst) begin
      foreach (m_nt[i]) m_nt[i] = 0;
      foreach (m_pm[i]) m_pm[i] = 0;
      foreach (m_bn[i]) m_bn[i] = 0;
      for (int s = 0; s < NS; s++) begin
        m_cm[s] = 0; m_en[s] = 0; m_in[s] = 0;
        for (int c = 0; c < NC; c++) m_st[c][s] = 0;
      end
      exp_rv = 0; exp_err = 0; exp_rd = 0; exp_pin = 0;
      return;
    end
    msk  = (req_size == 0) ? 0 : (req_size == 1) ? 3 : 7;
    base = int'(req_addr) & ~msk;
    core = int'(req_core);
    err  = req_valid && (req_size == 3 || !mapped(base));
    exp_rv = req_valid; exp_err = err; exp_rd = 0;
    n_pm = m_pm; n_cm = m_cm; n_en = m_en; n_st = m_st; w1c = '0;
    if (req_valid && !err) begin
      for (int i = 0; i <= msk; i++) begin
        int o = base + i;
        bit [7:0] d = req_wdata[8*i +: 8];
        if (!req_write) exp_rd[8*i +: 8] = rbyte(o, core);
        else if (in_range(o, 'hA0, 'hBF)) m_nt[o - 'hA0] = d;
        else if (in_range(o, 'hC0, 'hC7)) n_pm[o - 'hC0] = d;
        else if (in_range(o, 'h200, 'h21F)) for (int k = 0; k < 8; k++) n_en[(o - 'h200) * 8 + k] = d[k];
        else if (in_range(o, 'h280, 'h29F)) m_bn[o - 'h280] = d;
        else if (in_range(o, 'h400, 'h41F)) for (int k = 0; k < 8; k++) w1c[(o - 'h400) * 8 + k] = d[k];
        else if (in_range(o, 'h800, 'h8FF)) n_cm[o - 'h800] = d;
      end
    end
    for (int s = 0; s < NS; s++) begin
      int oc = pick(m_cm[s], NC);
      int nc = pick(n_cm[s], NC);
      if (w1c[s]) n_st[core][s] = 0;                                   // status clear
      if (m_in[s] && m_en[s] && !n_en[s]) n_st[oc][s] = 0;             // disabled while pending
      if (m_in[s] && !m_en[s] && n_en[s]) n_st[nc][s] = 1;             // enabled while pending
      if (m_in[s] && oc != nc) begin                                    // target moved
        n_st[oc][s] = 0;
        if (n_en[s]) n_st[nc][s] = 1;
      end
      if (irq_in[s] && !m_in[s] && n_en[s]) n_st[nc][s] = 1;           // input rise
    end
    exp_pin = 0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (n_st[c][s]) exp_pin[c*NP + pick(m_pm[s/32], NP)] = 1;
    m_pm = n_pm; m_cm = n_cm; m_en = n_en; m_st = n_st;
    for (int s = 0; s < NS; s++) m_in[s] = irq_in[s];
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    vectors++;
    if (rsp_valid !== exp_rv || rsp_err !== exp_err || rsp_rdata !== exp_rd || pin_out !== exp_pin) begin
      miscompares++;
      $display("FAIL %s: valid/err/rdata/pins act=%0b/%0b/%h/%h exp=%0b/%0b/%h/%h", tag,
               rsp_valid, rsp_err, rsp_rdata, pin_out, exp_rv, exp_err, exp_rd, exp_pin);
    end
  endtask

  task automatic acc(input bit w, input int addr, input int sz, input bit [63:0] d,
                     input int core, input string tag);
    req_valid = 1; req_write = w; req_addr = 12'(addr); req_size = 2'(sz);
    req_wdata = d; req_core = 2'(core);
    tick(tag);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #1;
    idle(3, "R1 reset");
    rst = 0;
    idle(1, "R1 after reset");
    acc(0, 'h200, 2, 0, 0, "R1 enable zero");
    acc(0, 'h800, 2, 0, 0, "R1 core map zero");

    acc(1, 'hA0, 2, 64'h1122334455667788, 0, "R3 node write");
    acc(0, 'hA0, 2, 0, 0, "R3 node dword");
    acc(0, 'hA3, 0, 0, 0, "R3 node byte");
    acc(0, 'hA6, 1, 0, 0, "R3 node word aligned down");
    acc(1, 'h284, 1, 64'hDEADBEEF, 0, "R3 bounce write");
    acc(0, 'h280, 2, 0, 0, "R3 bounce read");
    acc(1, 'h810, 2, 64'h0102040810204080, 0, "R3 core map write");
    acc(0, 'h812, 0, 0, 0, "R3 core map byte");

    acc(0, 'h200, 3, 0, 0, "R2 bad size read");
    acc(0, 'h000, 2, 0, 0, "R2 unmapped");
    acc(0, 'h900, 0, 0, 0, "R2 beyond map");
    acc(1, 'h200, 3, '1, 0, "R2 bad size write");
    acc(0, 'h200, 2, 0, 0, "R2 no effect");

    acc(1, 'h200, 2, '1, 0, "R3 enable 0..63");
    acc(1, 'h805, 0, 64'h04, 0, "R5 source5 core2");
    acc(1, 'hC0, 0, 64'h02, 0, "R4 group0 pin1");
    irq_in[5] = 1;
    tick("R6 rise enabled");
    idle(1, "R8 pin held");
    acc(0, 'h400, 0, 0, 2, "R9 read own status");
    acc(0, 'h400, 0, 0, 0, "R9 other core view");
    acc(0, 'h300, 0, 0, 0, "R6 raw pending");
    acc(1, 'h806, 0, 64'h30, 0, "R5 fallback core0");
    irq_in[6] = 1;
    tick("R5 rise to core0");

    irq_in[5] = 0;
    tick("R7 fall keeps latch");
    acc(0, 'h300, 0, 0, 0, "R7 raw cleared");

    irq_in[5] = 1;
    acc(1, 'h400, 0, 64'h20, 2, "R13 clear and rise same cycle");
    acc(0, 'h400, 0, 0, 2, "R13 latch kept");
    irq_in[5] = 0;
    acc(1, 'h400, 0, 64'h20, 0, "R9 other core clear no effect");
    acc(1, 'h400, 0, 64'h20, 2, "R9 w1c own");
    acc(0, 'h400, 2, 0, 2, "R9 readback");
    acc(1, 'h500, 2, '1, 0, "R9 upper range write");
    acc(0, 'h500, 2, 0, 0, "R9 upper range reads zero");

    acc(1, 'h205, 0, 64'h00, 0, "R10 disable 40..47");
    acc(1, 'hC1, 0, 64'h10, 0, "R4 group1 out-of-range pin");
    irq_in[40] = 1;
    tick("R6 rise disabled");
    acc(0, 'h405, 0, 0, 0, "R6 no latch");
    acc(1, 'h205, 0, 64'h01, 0, "R10 enable pending");
    acc(1, 'h205, 0, 64'h00, 0, "R10 disable pending");
    acc(1, 'h205, 0, 64'h01, 0, "R10 enable again");

    acc(1, 'h828, 0, 64'h08, 0, "R11 move to core3");
    acc(0, 'h405, 0, 0, 3, "R11 at core3");
    acc(1, 'h828, 0, 64'h80, 0, "R11 fallback to core0");
    acc(1, 'h828, 0, 64'h01, 0, "R11 same target");
    irq_in[40] = 0;
    tick("R7 fall");
    acc(1, 'h828, 0, 64'h02, 0, "R11 not pending no move");
    acc(0, 'h405, 0, 0, 0, "R11 stays at old core");

    acc(1, 'h300, 2, '1, 0, "R12 raw write ignored");
    acc(0, 'h300, 2, 0, 0, "R12 raw unchanged");
    acc(1, 'hC0, 0, 64'h08, 0, "R12 pin map store");
    acc(1, 'hA8, 2, '1, 0, "R12 node store");
    acc(1, 'h288, 2, '1, 0, "R12 bounce store");
    acc(0, 'h400, 2, 0, 0, "R12 status intact");

    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 9);
      int addrs[8] = '{'h200, 'h800, 'h808, 'h400, 'hC0, 'h300, 'h404, 'h0B8};
      if (r < 3) irq_in[15:0] = irq_in[15:0] ^ 16'($urandom_range(0, 65535));
      if (r < 7) begin
        req_valid = 1;
        req_write = 1'($urandom_range(0, 1));
        req_size  = 2'($urandom_range(0, 3));
        req_addr  = 12'(addrs[$urandom_range(0, 7)] + $urandom_range(0, 7));
        req_wdata = {32'($urandom), 32'($urandom)};
        req_core  = 2'($urandom_range(0, 3));
      end
      tick("R8 random mix");
      req_valid = 0;
    end
    irq_in = '0;
    idle(2, "R8 settle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule